// File: doc/BRIEF.md
# Full-Page SDRAM Burst Read Sequencer

This block models the read data path of one SDRAM bank whose open row holds 256 columns of 16-bit words. A write port preloads the row contents. A READ command carries a start column. The block then streams words onto a modelled DQ bus with an output-enable. The first word appears after a CAS latency of 2 or 3 clocks.

The burst length is chosen when the READ is taken. For lengths 1, 2, 4 and 8, the column wraps inside the aligned block of that size, and the burst ends by itself. A full-page burst steps through the row modulo 256 and never ends on its own. A BURST STOP halts it, and the outputs go quiet a CAS-latency number of clocks later. A later READ cancels a running burst, and its data follows the old data without a gap. After a stop, a programmable watchdog expects a precharge and flags a late one.

Top module: `sdram_fp_read_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) ends any burst, holds `dq_oe` low from the following cycle and clears `pre_late`.
- R2: `cl3`=0 selects CAS latency 2 and `cl3`=1 selects 3. If READ is sampled at edge n, its first word is on `dq` in the cycle after edge n+CL-1.
- R3: `bl_sel` 0,1,2,3 picks bursts of 1,2,4,8 words. Word k reads column (a & ~m) | ((a+k) & m), with m = length-1. After the last word `dq_oe` falls without any command.
- R4: `bl_sel` 4 to 7 picks full page. Word k reads column (a+k) mod 256, so word 256 is column a again, and the burst continues until a command ends it.
- R5: A BURST STOP sampled at edge s stops new words. Words from READ edges before s still come out, and `dq_oe` is low from the cycle after edge s+CL-1.
- R6: A READ sampled during a burst replaces the remaining words of that burst. Its first word directly follows the last surviving old word, with no idle cycle.
- R7: `dq_oe` is high exactly in the cycles that carry a burst word. Otherwise `dq` is driven to high impedance.
- R8: A BURST STOP at edge s arms a window of `pre_limit` (at least 1) edges. If no `pre_cmd` is sampled on edges s+1 to s+`pre_limit`, `pre_late` rises at edge s+`pre_limit` and stays high until reset.
- R9: A write with `wr_en` stores `wr_data` at column `wr_col`, and later bursts return it. A READ and a BURST STOP in the same cycle act as the READ alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rd | input | 1 | READ command |
| cmd_bst | input | 1 | BURST STOP command |
| cmd_col | input | 8 | Start column of a READ |
| bl_sel | input | 3 | Burst length select |
| cl3 | input | 1 | CAS latency select (0: 2, 1: 3) |
| pre_cmd | input | 1 | Precharge command |
| pre_limit | input | 16 | Stop-to-precharge window in cycles |
| wr_en | input | 1 | Page buffer write strobe |
| wr_col | input | 8 | Page buffer write column |
| wr_data | input | 16 | Page buffer write data |
| dq | output | 16 | Read data, high impedance when disabled |
| dq_oe | output | 1 | Output enable |
| pre_late | output | 1 | Sticky late-precharge flag |

## Verification
Word k of a READ sampled at edge n is due in the cycle after edge n+CL-1+k, unless a stop or a newer READ removes it. A stop or READ at edge e removes every word due from the cycle after edge e+CL-1. The bench numbers each edge and keeps a timeline of expected enable and data per edge, built from these rules. Inputs change on the falling edge, and each output is compared at the falling edge that follows its due rising edge. The late-precharge flag is checked on both sides of edge s+`pre_limit`.

// File: rtl/sdram_fp_read_seq.sv
module sdram_fp_read_seq #(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_rd,
  input  logic          cmd_bst,
  input  logic [CW-1:0] cmd_col,
  input  logic [2:0]    bl_sel,
  input  logic          cl3,
  input  logic          pre_cmd,
  input  logic [TW-1:0] pre_limit,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_col,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] dq,
  output logic          dq_oe,
  output logic          pre_late
);
  localparam int COLS = 1 << CW;
  localparam int PD = 3;

  logic [DW-1:0] page [COLS];
  logic          act, full, armed;
  logic [CW-1:0] col, mask, left, sel_mask;
  logic [TW-1:0] wcnt;
  logic          iss_v;
  logic [CW-1:0] iss_col;
  logic [PD-1:0] pv;
  logic [DW-1:0] pd [PD];

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic [CW-1:0] m);
    return (c & ~m) | (CW'(c + 1'b1) & m);
  endfunction

  always_comb begin
    case (bl_sel)
      3'd0:    sel_mask = '0;
      3'd1:    sel_mask = CW'(1);
      3'd2:    sel_mask = CW'(3);
      3'd3:    sel_mask = CW'(7);
      default: sel_mask = '1;
    endcase
  end

  always_comb begin
    iss_v   = cmd_rd || (act && !cmd_bst);
    iss_col = cmd_rd ? cmd_col : col;
  end

  always_ff @(posedge clk)
    if (wr_en) page[wr_col] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      full <= 1'b0;
      col  <= '0;
      mask <= '0;
      left <= '0;
    end else if (cmd_rd) begin
      act  <= sel_mask != '0;
      full <= bl_sel[2];
      mask <= sel_mask;
      left <= sel_mask;
      col  <= step(cmd_col, sel_mask);
    end else if (cmd_bst) begin
      act <= 1'b0;
    end else if (act) begin
      col <= step(col, mask);
      if (!full) begin
        left <= left - 1'b1;
        if (left == CW'(1)) act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pv <= '0;
    else     pv <= {pv[PD-2:0], iss_v};
  end

  always_ff @(posedge clk) begin
    pd[0] <= page[iss_col];
    for (int i = 1; i < PD; i++) pd[i] <= pd[i-1];
  end

  assign dq_oe = cl3 ? pv[2] : pv[1];
  assign dq    = dq_oe ? (cl3 ? pd[2] : pd[1]) : 'z;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      wcnt     <= '0;
      pre_late <= 1'b0;
    end else if (cmd_bst && !cmd_rd) begin
      armed <= 1'b1;
      wcnt  <= '0;
    end else if (armed) begin
      if (pre_cmd) armed <= 1'b0;
      else if (TW'(wcnt + 1'b1) == pre_limit) begin
        pre_late <= 1'b1;
        armed    <= 1'b0;
      end else wcnt <= wcnt + 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !dq_oe && !pre_late);
  p_first_issue_r2: assert property (@(posedge clk) disable iff (rst) cmd_rd |=> pv[0]);
  p_fixed_end_r3: assert property (@(posedge clk) disable iff (rst)
    act && !full && left == CW'(1) && !cmd_rd |=> !act);
  p_full_step_r4: assert property (@(posedge clk) disable iff (rst)
    act && full && !cmd_rd && !cmd_bst |=> col == CW'($past(col) + 1'b1));
  p_stop_cl2_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_bst && !cmd_rd && !cl3) ##1 !cmd_rd |=> !dq_oe);
  p_stop_cl3_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_bst && !cmd_rd && cl3) ##1 !cmd_rd ##1 !cmd_rd |=> !dq_oe);
  p_late_sticky_r8: assert property (@(posedge clk) disable iff (rst) pre_late |=> pre_late);
endmodule

// File: tb/sdram_fp_read_seq_tb.sv
module sdram_fp_read_seq_tb_top;
  localparam int HOR = 1024;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_rd = 0, cmd_bst = 0, cl3 = 0, pre_cmd = 0, wr_en = 0;
  logic [7:0] cmd_col = 0, wr_col = 0;
  logic [2:0] bl_sel = 0;
  logic [15:0] pre_limit = 16'hFFFF, wr_data = 0;
  logic [15:0] dq;
  logic dq_oe, pre_late;

  sdram_fp_read_seq dut_i (
    .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_bst(cmd_bst), .cmd_col(cmd_col),
    .bl_sel(bl_sel), .cl3(cl3), .pre_cmd(pre_cmd), .pre_limit(pre_limit),
    .wr_en(wr_en), .wr_col(wr_col), .wr_data(wr_data),
    .dq(dq), .dq_oe(dq_oe), .pre_late(pre_late));

  always #10 clk = ~clk;

  int errors = 0, checks = 0, ec = 0;
  bit done = 0;
  logic [15:0] page [256];
  bit exp_v [HOR];
  logic [15:0] exp_d [HOR];

  function automatic int lat();
    return cl3 ? 3 : 2;
  endfunction

  function automatic logic [7:0] beat_col(input logic [7:0] a, input logic [2:0] sel, input int k);
    logic [7:0] m;
    m = sel[2] ? 8'hFF : 8'((1 << sel) - 1);
    return (a & ~m) | (8'(a + k) & m);
  endfunction

  function automatic void clear_from(input int idx);
    for (int i = (idx < 0 ? 0 : idx); i < HOR; i++) exp_v[i] = 0;
  endfunction

  function automatic void mark_read(input int e, input logic [7:0] a, input logic [2:0] sel);
    int st, n;
    st = e + lat() - 1;
    clear_from(st);
    n = sel[2] ? HOR : (1 << sel);
    for (int k = 0; k < n && st + k < HOR; k++) begin
      exp_v[st+k] = 1;
      exp_d[st+k] = page[beat_col(a, sel, k)];
    end
  endfunction

  function automatic void mark_stop(input int e);
    clear_from(e + lat() - 1);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s edge %0d: actual %h expected %h", tag, ec, act, expv);
    end
  endtask

  task automatic new_scn();
    clear_from(0);
    ec = 0;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    ec++;
    @(negedge clk);
    if (ec < HOR) begin
      check(tag, {15'd0, dq_oe}, {15'd0, exp_v[ec]});
      if (exp_v[ec] && dq_oe) check(tag, dq, exp_d[ec]);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sel, input string tag);
    cmd_rd = 1; cmd_col = a; bl_sel = sel;
    mark_read(ec + 1, a, sel);
    tick(tag);
    cmd_rd = 0;
  endtask

  task automatic bst(input string tag);
    cmd_bst = 1;
    mark_stop(ec + 1);
    tick(tag);
    cmd_bst = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic do_reset();
    rst = 1;
    clear_from(ec + 1);
    tick("R1");
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    check("R1", {15'd0, dq_oe}, 16'd0);
    check("R1", {15'd0, pre_late}, 16'd0);

    for (int c = 0; c < 256; c++) begin
      page[c] = 16'($urandom);
      wr_en = 1; wr_col = 8'(c); wr_data = page[c];
      @(posedge clk); @(negedge clk);
    end
    wr_en = 0;

    for (int l = 0; l < 2; l++) begin
      cl3 = l[0];
      new_scn();
      for (int s = 0; s < 4; s++) begin
        rd(8'hFD, 3'(s), "R2/R3/R9");
        idle(12, "R3/R7");
      end
      rd(8'h16, 3'd3, "R3");
      idle(12, "R3/R7");
    end

    cl3 = 1;
    new_scn();
    rd(8'hF0, 3'd7, "R4");
    idle(300, "R4");
    bst("R5");
    idle(8, "R5/R7");

    cl3 = 0;
    new_scn();
    rd(8'h80, 3'd4, "R4");
    idle(20, "R4");
    bst("R5");
    idle(8, "R5/R7");

    for (int l = 0; l < 2; l++) begin
      cl3 = l[0];
      new_scn();
      rd(8'h20, 3'd3, "R6");
      idle(2, "R6");
      rd(8'h43, 3'd2, "R6");
      rd(8'h77, 3'd1, "R6");
      idle(10, "R6");
      cmd_bst = 1;
      rd(8'h05, 3'd2, "R9");
      cmd_bst = 0;
      idle(10, "R9");
    end

    for (int l = 0; l < 2; l++) begin
      cl3 = l[0];
      new_scn();
      for (int i = 0; i < 900; i++) begin
        int r;
        r = int'($urandom_range(0, 99));
        if (r < 6) rd(8'($urandom), 3'($urandom), "R6/R7");
        else if (r < 9) bst("R5/R7");
        else tick("R7");
      end
      bst("R5");
      idle(8, "R7");
    end

    new_scn();
    cl3 = 0;
    pre_limit = 16'd5;
    rd(8'h10, 3'd7, "R8");
    idle(3, "R8");
    bst("R8");
    idle(4, "R8");
    check("R8", {15'd0, pre_late}, 16'd0);
    pre_cmd = 1;
    tick("R8");
    pre_cmd = 0;
    idle(6, "R8");
    check("R8", {15'd0, pre_late}, 16'd0);
    bst("R8");
    idle(4, "R8");
    check("R8", {15'd0, pre_late}, 16'd0);
    tick("R8");
    check("R8", {15'd0, pre_late}, 16'd1);
    pre_cmd = 1;
    idle(3, "R8");
    pre_cmd = 0;
    check("R8", {15'd0, pre_late}, 16'd1);

    rd(8'h33, 3'd7, "R1");
    idle(5, "R1");
    do_reset();
    check("R1", {15'd0, dq_oe}, 16'd0);
    check("R1", {15'd0, pre_late}, 16'd0);
    idle(6, "R1");
    pre_limit = 16'hFFFF;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule